// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the status register of a serial NOR flash device and decides which decoded instructions take effect. A command front end, which does the serial shifting and opcode decoding, presents one instruction strobe per cycle: write enable, write disable, read status, write status (with a data byte), page program, sector erase, block erase, chip erase, or suspend. A busy timer elsewhere returns a one-cycle done pulse when a program, erase or status write finishes. The controller also samples the active-low write-protect pin.

In the same cycle as the strobe, the block answers each instruction with accept or reject. The status byte and the register state change on the next clock edge. A separate flag, derived from the current state, tells the array sequencer whether program and erase are allowed. The non-volatile bits (the protect field, the two spare bits and the protect-lock bit) are registers cleared only by a factory reset input. The power-on reset clears only the volatile busy and latch bits, so a power cycle keeps the protection settings.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte has the busy flag in bit 0, the write latch in bit 1, the block-protect field in bits 4:2, two spare non-volatile bits in 6:5 and the protect-lock bit in bit 7. After factory reset the byte reads 0x00.
- R2: When idle, write enable is accepted and sets bit 1 on the next edge. Write disable is accepted and clears it.
- R3: Page program, sector erase, block erase and chip erase are accepted only when bit 1 is 1 and bit 0 is 0. Acceptance sets bit 0 and clears bit 1 on the next edge. A rejected program or erase changes nothing.
- R4: progEraseOk is 1 exactly when bit 1 is 1 and bit 0 is 0.
- R5: While bit 0 is 1, every instruction except read status and suspend is rejected and leaves the status byte unchanged. Suspend is accepted only while bit 0 is 1, is rejected when idle, and never changes the status byte.
- R6: A done pulse while bit 0 is 1 clears bit 0 on the next edge. A done pulse while idle has no effect.
- R7: Write status is rejected when bit 1 is 0. It is also rejected when bit 7 is 1 and wpN is 0, and then bit 1 stays set. Otherwise it is accepted: bits 7:2 load from data bits 7:2, data bits 1:0 are ignored, bit 0 sets and bit 1 clears.
- R8: Read status is always accepted and changes nothing.
- R9: Asserting rstN low while factoryRstN stays high clears bits 1:0 and keeps bits 7:2.
- R10: In a cycle with an instruction strobe, exactly one of cmdAccept and cmdReject is 1. In a cycle with no strobe, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, async; clears volatile bits |
| factoryRstN | input | 1 | Factory reset, active low, async; clears non-volatile bits |
| cmdWren | input | 1 | Write enable strobe |
| cmdWrdi | input | 1 | Write disable strobe |
| cmdRdsr | input | 1 | Read status strobe |
| cmdWrsr | input | 1 | Write status strobe |
| wrsrData | input | 8 | Data byte for write status |
| cmdPp | input | 1 | Page program strobe |
| cmdSe | input | 1 | Sector erase strobe |
| cmdBe | input | 1 | Block erase strobe |
| cmdCe | input | 1 | Chip erase strobe |
| cmdSusp | input | 1 | Erase/program suspend strobe |
| wpN | input | 1 | Write-protect pin, active low |
| opDone | input | 1 | Busy timer completion pulse |
| statusByte | output | 8 | Current status register |
| cmdAccept | output | 1 | Instruction accepted this cycle |
| cmdReject | output | 1 | Instruction rejected this cycle |
| progEraseOk | output | 1 | Program/erase currently permitted |

## Verification
The assertions check on every cycle the rules that are local in time. Busy rejection and a frozen status while busy, accept and reject never both high, lock-bit blocking of status writes, program/erase gating and its effect on the next edge, completion clearing busy, and read status leaving the byte intact all hold cycle by cycle. Only the bench scenarios show the full sequences. These include the exact bit positions loaded by a status write, ignored data bits, the lock engaging only after it has been written, and a power cycle keeping the non-volatile bits while the latch and busy bits clear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W  = 8;
  localparam int WIP_POS = 0;
  localparam int WEL_POS = 1;
  localparam int NV_LO   = 2;
  localparam int NV_W    = STAT_W - NV_LO;

  // strobes from control to datapath
  typedef struct packed {
    logic setWip;
    logic clrWip;
    logic setWel;
    logic clrWel;
    logic loadNv;
  } statCtl_t;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic     cmdWren,
  input  logic     cmdWrdi,
  input  logic     cmdRdsr,
  input  logic     cmdWrsr,
  input  logic     cmdPp,
  input  logic     cmdSe,
  input  logic     cmdBe,
  input  logic     cmdCe,
  input  logic     cmdSusp,
  input  logic     wpN,
  input  logic     opDone,
  input  logic     wip,
  input  logic     wel,
  input  logic     srp,
  output statCtl_t ctl,
  output logic     cmdAccept,
  output logic     cmdReject
);
  logic anyCmd;
  logic peCmd;
  logic wrsrOk;

  assign peCmd  = cmdPp | cmdSe | cmdBe | cmdCe;
  assign anyCmd = cmdWren | cmdWrdi | cmdRdsr | cmdWrsr | cmdSusp | peCmd;
  assign wrsrOk = wel && !(srp && !wpN);

  always_comb begin
    ctl       = '0;
    cmdAccept = 1'b0;
    if (wip) begin
      // busy: only status read and suspend get through
      cmdAccept = cmdRdsr | cmdSusp;
      if (opDone) ctl.clrWip = 1'b1;
    end else if (cmdWren) begin
      cmdAccept  = 1'b1;
      ctl.setWel = 1'b1;
    end else if (cmdWrdi) begin
      cmdAccept  = 1'b1;
      ctl.clrWel = 1'b1;
    end else if (cmdRdsr) begin
      cmdAccept = 1'b1;
    end else if (cmdWrsr && wrsrOk) begin
      cmdAccept  = 1'b1;
      ctl.setWip = 1'b1;
      ctl.clrWel = 1'b1;
      ctl.loadNv = 1'b1;
    end else if (peCmd && wel) begin
      cmdAccept  = 1'b1;
      ctl.setWip = 1'b1;
      ctl.clrWel = 1'b1;
    end
  end

  assign cmdReject = anyCmd && !cmdAccept;
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              factoryRstN,
  input  statCtl_t          ctl,
  input  logic [STAT_W-1:0] wrData,
  output logic              wip,
  output logic              wel,
  output logic [NV_W-1:0]   nvBits
);
  // volatile bits: cleared by power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wip <= 1'b0;
      wel <= 1'b0;
    end else begin
      if (ctl.setWip)      wip <= 1'b1;
      else if (ctl.clrWip) wip <= 1'b0;
      if (ctl.setWel)      wel <= 1'b1;
      else if (ctl.clrWel) wel <= 1'b0;
    end
  end

  // non-volatile bits: survive power cycles
  always_ff @(posedge clk or negedge factoryRstN) begin
    if (!factoryRstN)    nvBits <= '0;
    else if (ctl.loadNv) nvBits <= wrData[STAT_W-1:NV_LO];
  end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              factoryRstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdRdsr,
  input  logic              cmdWrsr,
  input  logic [STAT_W-1:0] wrsrData,
  input  logic              cmdPp,
  input  logic              cmdSe,
  input  logic              cmdBe,
  input  logic              cmdCe,
  input  logic              cmdSusp,
  input  logic              wpN,
  input  logic              opDone,
  output logic [STAT_W-1:0] statusByte,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              progEraseOk
);
  statCtl_t        ctl;
  logic            wip;
  logic            wel;
  logic [NV_W-1:0] nvBits;

  fsr_ctrl u_ctrl (
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdRdsr(cmdRdsr), .cmdWrsr(cmdWrsr),
    .cmdPp(cmdPp), .cmdSe(cmdSe), .cmdBe(cmdBe), .cmdCe(cmdCe),
    .cmdSusp(cmdSusp), .wpN(wpN), .opDone(opDone),
    .wip(wip), .wel(wel), .srp(nvBits[NV_W-1]),
    .ctl(ctl), .cmdAccept(cmdAccept), .cmdReject(cmdReject)
  );

  fsr_datapath u_dp (
    .clk(clk), .rstN(rstN), .factoryRstN(factoryRstN),
    .ctl(ctl), .wrData(wrsrData),
    .wip(wip), .wel(wel), .nvBits(nvBits)
  );

  assign statusByte  = {nvBits, wel, wip};
  assign progEraseOk = wel & ~wip;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       factoryRstN,
  input logic       cmdWren,
  input logic       cmdWrdi,
  input logic       cmdRdsr,
  input logic       cmdWrsr,
  input logic       cmdPp,
  input logic       cmdSe,
  input logic       cmdBe,
  input logic       cmdCe,
  input logic       wpN,
  input logic       opDone,
  input logic [7:0] statusByte,
  input logic       cmdAccept,
  input logic       cmdReject,
  input logic       progEraseOk
);
  logic peCmd;
  logic blockedCmd;
  assign peCmd      = cmdPp | cmdSe | cmdBe | cmdCe;
  assign blockedCmd = peCmd | cmdWren | cmdWrdi | cmdWrsr;

  assert_busy_reject_R5: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    statusByte[0] && blockedCmd |-> cmdReject);
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    statusByte[0] && !opDone |=> $stable(statusByte));
  assert_pe_effect_R3: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    peCmd && cmdAccept |=> statusByte[0] && !statusByte[1]);
  assert_pe_gate_R4: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    peCmd && !progEraseOk |-> cmdReject);
  assert_lock_reject_R7: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    cmdWrsr && statusByte[7] && !wpN |-> cmdReject);
  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    cmdWrsr && statusByte[7] && !wpN && !opDone |=> $stable(statusByte));
  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    statusByte[0] && opDone |=> !statusByte[0]);
  assert_read_accept_R8: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    cmdRdsr |-> cmdAccept);
  assert_read_quiet_R8: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    cmdRdsr && !opDone |=> $stable(statusByte));
  assert_wren_set_R2: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    cmdWren && !statusByte[0] |=> statusByte[1]);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    !(cmdAccept && cmdReject));
endmodule

bind flash_status_ctrl fsr_checker u_fsr_checker (
  .clk(clk), .rstN(rstN), .factoryRstN(factoryRstN),
  .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdRdsr(cmdRdsr), .cmdWrsr(cmdWrsr),
  .cmdPp(cmdPp), .cmdSe(cmdSe), .cmdBe(cmdBe), .cmdCe(cmdCe),
  .wpN(wpN), .opDone(opDone), .statusByte(statusByte),
  .cmdAccept(cmdAccept), .cmdReject(cmdReject), .progEraseOk(progEraseOk)
);

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic factoryRstN = 1'b0;
  logic cmdWren = 0, cmdWrdi = 0, cmdRdsr = 0, cmdWrsr = 0;
  logic cmdPp = 0, cmdSe = 0, cmdBe = 0, cmdCe = 0, cmdSusp = 0;
  logic [7:0] wrsrData = 8'h00;
  logic wpN = 1'b1;
  logic opDone = 1'b0;
  logic [7:0] statusByte;
  logic cmdAccept, cmdReject, progEraseOk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_status_ctrl i_flash_status_ctrl (
    .clk(clk), .rstN(rstN), .factoryRstN(factoryRstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdRdsr(cmdRdsr), .cmdWrsr(cmdWrsr),
    .wrsrData(wrsrData), .cmdPp(cmdPp), .cmdSe(cmdSe), .cmdBe(cmdBe), .cmdCe(cmdCe),
    .cmdSusp(cmdSusp), .wpN(wpN), .opDone(opDone),
    .statusByte(statusByte), .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .progEraseOk(progEraseOk)
  );

  // vector: {cmd[3:0], data[7:0], wpN, done, resp[1:0], status[7:0]}
  // cmd: 0 none,1 wren,2 wrdi,3 rdsr,4 wrsr,5 pp,6 se,7 be,8 ce,9 susp
  // resp: 0 neither, 1 accept, 2 reject
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3, 8'h00, 1'b1, 1'b0, 2'd1, 8'h00}, // R8 read idle
    {4'd5, 8'h00, 1'b1, 1'b0, 2'd2, 8'h00}, // R3 pp without latch
    {4'd4, 8'hFF, 1'b1, 1'b0, 2'd2, 8'h00}, // R7 wrsr without latch
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h02}, // R2 wren
    {4'd2, 8'h00, 1'b1, 1'b0, 2'd1, 8'h00}, // R2 wrdi
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h02}, // R2
    {4'd6, 8'h00, 1'b1, 1'b0, 2'd1, 8'h01}, // R3 se accepted
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd2, 8'h01}, // R5 wren while busy
    {4'd3, 8'h00, 1'b1, 1'b0, 2'd1, 8'h01}, // R5 R8 read while busy
    {4'd9, 8'h00, 1'b1, 1'b0, 2'd1, 8'h01}, // R5 suspend while busy
    {4'd8, 8'h00, 1'b1, 1'b0, 2'd2, 8'h01}, // R5 ce while busy
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h00}, // R6 done
    {4'd9, 8'h00, 1'b1, 1'b0, 2'd2, 8'h00}, // R5 suspend idle
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h02}, // R2
    {4'd4, 8'h9F, 1'b1, 1'b0, 2'd1, 8'h9D}, // R7 R1 write, low data bits ignored
    {4'd4, 8'h00, 1'b1, 1'b0, 2'd2, 8'h9D}, // R5 wrsr while busy
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h9C}, // R6
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h9E}, // R2
    {4'd4, 8'h00, 1'b0, 1'b0, 2'd2, 8'h9E}, // R7 locked by pin, latch kept
    {4'd5, 8'h00, 1'b0, 1'b0, 2'd1, 8'h9D}, // R3 pp not gated by pin
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h9C}, // R6
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h9C}, // R6 done while idle
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h9E}, // R2
    {4'd4, 8'h60, 1'b1, 1'b0, 2'd1, 8'h61}, // R7 pin high unlocks, R1 spare bits
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h60}, // R6
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h62}, // R2
    {4'd7, 8'h00, 1'b1, 1'b0, 2'd1, 8'h61}, // R3 be
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h60}, // R6
    {4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h62}, // R2
    {4'd4, 8'h00, 1'b0, 1'b0, 2'd1, 8'h01}, // R7 lock clear, pin low allowed
    {4'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h00}  // R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [7:0] d, input logic w, input logic dn);
    cmdWren = (c == 4'd1); cmdWrdi = (c == 4'd2); cmdRdsr = (c == 4'd3);
    cmdWrsr = (c == 4'd4); cmdPp   = (c == 4'd5); cmdSe   = (c == 4'd6);
    cmdBe   = (c == 4'd7); cmdCe   = (c == 4'd8); cmdSusp = (c == 4'd9);
    wrsrData = d; wpN = w; opDone = dn;
  endtask

  // one instruction: response checked before the edge, status after it
  task automatic step(input string req, input logic [3:0] c, input logic [7:0] d,
                      input logic w, input logic dn, input logic [1:0] resp,
                      input logic [7:0] stat);
    @(negedge clk);
    drive(c, d, w, dn);
    #1;
    check({req, " response"}, {6'd0, cmdReject, cmdAccept}, {6'd0, resp});
    @(negedge clk);
    drive(4'd0, 8'h00, 1'b1, 1'b0);
    #1;
    check({req, " status"}, statusByte, stat);
    check("R4 progEraseOk", {7'd0, progEraseOk}, {7'd0, stat[1] & ~stat[0]});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; factoryRstN = 1'b1;
    #1;
    check("R1 factory status", statusByte, 8'h00);
    check("R10 idle response", {6'd0, cmdReject, cmdAccept}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step($sformatf("vector %0d", i), VEC[i][23:20], VEC[i][19:12], VEC[i][11],
           VEC[i][10], VEC[i][9:8], VEC[i][7:0]);
    end

    // R9 power cycle keeps non-volatile bits
    step("R9 setup wren", 4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h02);
    step("R9 setup wrsr", 4'd4, 8'h1C, 1'b1, 1'b0, 2'd1, 8'h1D);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R9 busy cleared, protect kept", statusByte, 8'h1C);
    step("R9 wren", 4'd1, 8'h00, 1'b1, 1'b0, 2'd1, 8'h1E);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R9 latch cleared", statusByte, 8'h1C);

    // R1 factory reset clears everything
    @(negedge clk); rstN = 1'b0; factoryRstN = 1'b0;
    @(negedge clk); rstN = 1'b1; factoryRstN = 1'b1;
    #1;
    check("R1 factory reset", statusByte, 8'h00);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule